// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the arithmetic and logic stage of a small 8-bit datapath. Each clock it takes an operation code, the accumulator value, a second operand and the current five-bit flag vector. One cycle later it presents the new accumulator value and the new flag vector on registered outputs. A surrounding core feeds the outputs back into its accumulator and flag registers. Register-file access and memory addressing belong to that core, not to this block.

Every operation has its own rule for each flag: the flag is computed from the result, forced to a constant, or copied through from the input. Decimal adjust corrects a binary sum of two packed BCD bytes. It adds 6 to either nibble or to both, guided by the nibble values and by the incoming auxiliary carry and carry.

Top module: `acc_alu`

## Requirements
- R1: While `rst_ni` is low, `result_o` and `flags_o` are zero. Otherwise the outputs show the effect of the inputs sampled at the previous rising clock edge. The flag vector layout is bit 4 sign, bit 3 zero, bit 2 auxiliary carry, bit 1 parity, bit 0 carry.
- R2: Op 0 (add) and op 1 (add with carry) return acc + opnd + cin, where cin is the incoming carry for op 1 and 0 for op 0. Carry is the carry out of bit 7. Auxiliary carry is the carry out of bit 3.
- R3: Op 2 (subtract) and op 3 (subtract with borrow) return acc - opnd - bin, where bin is the incoming carry for op 3 and 0 for op 2. Carry is set on a borrow out of bit 7. Auxiliary carry is set on a borrow out of bit 3.
- R4: Op 4 returns opnd + 1 and op 5 returns opnd - 1. Auxiliary carry reflects the carry or borrow across bit 3. Carry is copied from the input.
- R5: Op 6 returns acc AND opnd, clears carry and sets auxiliary carry.
- R6: Op 7 (XOR) and op 8 (OR) return the bitwise result and clear both carry and auxiliary carry.
- R7: Op 9 rotates acc left by one position. Bit 7 goes to bit 0 and to carry. Sign, zero, parity and auxiliary carry are copied from the input.
- R8: Op 10 rotates acc right by one position. Bit 0 goes to bit 7 and to carry. Sign, zero, parity and auxiliary carry are copied from the input.
- R9: Op 11 (decimal adjust) first adds 6 to acc when the low nibble exceeds 9 or the incoming auxiliary carry is set. The output auxiliary carry is the carry out of the low nibble in that addition.
- R10: Op 11 then adds 0x60 when the high nibble of the intermediate value exceeds 9 or the incoming carry is set. The output carry is set when the incoming carry was set or when either addition overflows 8 bits.
- R11: For ops 0 to 8 and 11, sign equals result bit 7, zero is set when the result is 0, and parity is set when the result has an even number of one bits.
- R12: Ops 12 to 15 return acc unchanged and copy all five flags from the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 5 | Incoming flags {S,Z,AC,P,CY} |
| result_o | output | 8 | Registered result |
| flags_o | output | 5 | Registered flags {S,Z,AC,P,CY} |

## Verification
Within a single decimal adjust, the low-nibble and high-nibble corrections can both fire. The low correction can also push the high nibble past 9, which then triggers the high correction. Inputs such as 0x9A, 0x99 with auxiliary carry set, and 0xFF are applied to provoke these cases. Each is judged against a behavioural model that evaluates both steps in order. The result, auxiliary carry and the sticky carry are compared on the following clock.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int FLG_W  = 5;
  localparam int FLG_S  = 4;
  localparam int FLG_Z  = 3;
  localparam int FLG_AC = 2;
  localparam int FLG_P  = 1;
  localparam int FLG_CY = 0;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_INC = 4'd4,
    OP_DEC = 4'd5,
    OP_AND = 4'd6,
    OP_XOR = 4'd7,
    OP_OR  = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10,
    OP_DAA = 4'd11,
    OP_RS0 = 4'd12,
    OP_RS1 = 4'd13,
    OP_RS2 = 4'd14,
    OP_RS3 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_ARITH = 2'd0,
    SRC_LOGIC = 2'd1,
    SRC_BCD   = 2'd2,
    SRC_PASS  = 2'd3
  } alu_src_e;
endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
(
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              ac_o
);
  logic [DATA_W:0] full;
  logic [NIB_W:0]  low;
  logic            cin;

  always_comb begin
    cin  = ((op_i == OP_ADC) || (op_i == OP_SBB)) ? cy_i : 1'b0;
    full = '0;
    low  = '0;
    cy_o = cy_i;
    unique case (op_i)
      OP_ADD, OP_ADC: begin
        full = {1'b0, acc_i} + {1'b0, opnd_i} + {{DATA_W{1'b0}}, cin};
        low  = {1'b0, acc_i[NIB_W-1:0]} + {1'b0, opnd_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
        cy_o = full[DATA_W];
      end
      OP_SUB, OP_SBB: begin
        full = {1'b0, acc_i} - {1'b0, opnd_i} - {{DATA_W{1'b0}}, cin};
        low  = {1'b0, acc_i[NIB_W-1:0]} - {1'b0, opnd_i[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};
        cy_o = full[DATA_W];
      end
      OP_INC: begin
        full = {1'b0, opnd_i} + {{DATA_W{1'b0}}, 1'b1};
        low  = {1'b0, opnd_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, 1'b1};
      end
      OP_DEC: begin
        full = {1'b0, opnd_i} - {{DATA_W{1'b0}}, 1'b1};
        low  = {1'b0, opnd_i[NIB_W-1:0]} - {{NIB_W{1'b0}}, 1'b1};
      end
      default: begin
        full = '0;
        low  = '0;
      end
    endcase
    res_o = full[DATA_W-1:0];
    ac_o  = low[NIB_W];
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
(
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);
  always_comb begin
    res_o = acc_i;
    cy_o  = cy_i;
    unique case (op_i)
      OP_AND: begin res_o = acc_i & opnd_i; cy_o = 1'b0; end
      OP_XOR: begin res_o = acc_i ^ opnd_i; cy_o = 1'b0; end
      OP_OR:  begin res_o = acc_i | opnd_i; cy_o = 1'b0; end
      OP_ROL: begin
        res_o = {acc_i[DATA_W-2:0], acc_i[DATA_W-1]};
        cy_o  = acc_i[DATA_W-1];
      end
      OP_ROR: begin
        res_o = {acc_i[0], acc_i[DATA_W-1:1]};
        cy_o  = acc_i[0];
      end
      default: begin res_o = acc_i; cy_o = cy_i; end
    endcase
  end
endmodule

// File: rtl/alu_bcd.sv
module alu_bcd
  import alu_pkg::*;
(
  input  logic [DATA_W-1:0] acc_i,
  input  logic              ac_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ac_o,
  output logic              cy_o
);
  localparam logic [NIB_W-1:0] NIB_MAX = NIB_W'(9);
  localparam logic [NIB_W-1:0] NIB_FIX = NIB_W'(6);

  logic            lo_fix, hi_fix;
  logic [NIB_W:0]  lo_sum;
  logic [DATA_W:0] mid, fin;

  always_comb begin
    lo_fix = (acc_i[NIB_W-1:0] > NIB_MAX) || ac_i;
    lo_sum = {1'b0, acc_i[NIB_W-1:0]} + {1'b0, (lo_fix ? NIB_FIX : {NIB_W{1'b0}})};
    mid    = {1'b0, acc_i} + {{(DATA_W-NIB_W+1){1'b0}}, (lo_fix ? NIB_FIX : {NIB_W{1'b0}})};
    hi_fix = (mid[DATA_W-1:NIB_W] > NIB_MAX) || cy_i;
    // high correction applies to the post-low-step byte; low overflow stays sticky
    fin    = {1'b0, mid[DATA_W-1:0]} + {1'b0, (hi_fix ? NIB_FIX : {NIB_W{1'b0}}), {NIB_W{1'b0}}};
    res_o  = fin[DATA_W-1:0];
    ac_o   = lo_sum[NIB_W];
    cy_o   = cy_i | mid[DATA_W] | fin[DATA_W];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [FLG_W-1:0]  flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLG_W-1:0]  flags_o
);
  alu_op_e           op;
  alu_src_e          src;
  logic [DATA_W-1:0] ar_res, lg_res, bcd_res, res_d;
  logic              ar_cy, ar_ac, lg_cy, bcd_cy, bcd_ac;
  logic [FLG_W-1:0]  flags_d;
  logic              szp_upd;

  assign op = alu_op_e'(op_i);

  alu_arith u_arith (
    .op_i(op), .acc_i(acc_i), .opnd_i(opnd_i), .cy_i(flags_i[FLG_CY]),
    .res_o(ar_res), .cy_o(ar_cy), .ac_o(ar_ac)
  );

  alu_logic u_logic (
    .op_i(op), .acc_i(acc_i), .opnd_i(opnd_i), .cy_i(flags_i[FLG_CY]),
    .res_o(lg_res), .cy_o(lg_cy)
  );

  alu_bcd u_bcd (
    .acc_i(acc_i), .ac_i(flags_i[FLG_AC]), .cy_i(flags_i[FLG_CY]),
    .res_o(bcd_res), .ac_o(bcd_ac), .cy_o(bcd_cy)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC, OP_DEC: src = SRC_ARITH;
      OP_AND, OP_XOR, OP_OR, OP_ROL, OP_ROR:          src = SRC_LOGIC;
      OP_DAA:                                         src = SRC_BCD;
      default:                                        src = SRC_PASS;
    endcase
    szp_upd = (src != SRC_PASS) && (op != OP_ROL) && (op != OP_ROR);
  end

  always_comb begin
    flags_d = flags_i;
    unique case (src)
      SRC_ARITH: begin
        res_d = ar_res;
        flags_d[FLG_CY] = ar_cy;
        flags_d[FLG_AC] = ar_ac;
      end
      SRC_LOGIC: begin
        res_d = lg_res;
        flags_d[FLG_CY] = lg_cy;
        if (op == OP_AND) flags_d[FLG_AC] = 1'b1;
        else if (op == OP_XOR || op == OP_OR) flags_d[FLG_AC] = 1'b0;
      end
      SRC_BCD: begin
        res_d = bcd_res;
        flags_d[FLG_CY] = bcd_cy;
        flags_d[FLG_AC] = bcd_ac;
      end
      default: res_d = acc_i;
    endcase
    if (szp_upd) begin
      flags_d[FLG_S] = res_d[DATA_W-1];
      flags_d[FLG_Z] = (res_d == '0);
      flags_d[FLG_P] = ~^res_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      result_o <= res_d;
      flags_o  <= flags_d;
    end
  end

  assert_and_flags_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd6) |=> (flags_o[FLG_AC] && !flags_o[FLG_CY]));

  assert_xor_or_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd7 || op_i == 4'd8) |=> (!flags_o[FLG_AC] && !flags_o[FLG_CY]));

  assert_incdec_keep_cy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd4 || op_i == 4'd5) |=> (flags_o[FLG_CY] == $past(flags_i[FLG_CY])));

  assert_rol_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd9) |=> (flags_o[4:1] == $past(flags_i[4:1])
                        && flags_o[FLG_CY] == result_o[0]));

  assert_ror_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd10) |=> (flags_o[4:1] == $past(flags_i[4:1])
                         && flags_o[FLG_CY] == result_o[DATA_W-1]));

  assert_daa_sticky_cy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd11 && flags_i[FLG_CY]) |=> flags_o[FLG_CY]);

  assert_szp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i <= 4'd8 || op_i == 4'd11) |=>
      (flags_o[FLG_S] == result_o[DATA_W-1] && flags_o[FLG_Z] == (result_o == '0)
       && flags_o[FLG_P] == ($countones(result_o) % 2 == 0)));

  assert_pass_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd12) |=> (result_o == $past(acc_i) && flags_o == $past(flags_i)));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) assert_reset_R1: assert (result_o == '0 && flags_o == '0);
  end
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic [4:0] flags_i = '0;
  logic [7:0] result_o;
  logic [4:0] flags_o;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  bit done = 0;

  always #2 clk_i = ~clk_i;

  acc_alu u_acc_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o)
  );

  function automatic string req_of(int op);
    case (op)
      0, 1:     return "R2";
      2, 3:     return "R3";
      4, 5:     return "R4";
      6:        return "R5";
      7, 8:     return "R6";
      9:        return "R7";
      10:       return "R8";
      11:       return "R9/R10";
      default:  return "R12";
    endcase
  endfunction

  function automatic int even_par(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  // packs {op, result, flags} into one int
  function automatic int model(int op, int a, int b, int f);
    int r, s, z, ac, p, cy, cin, t, lo, hi;
    s = (f >> 4) & 1; z = (f >> 3) & 1; ac = (f >> 2) & 1; p = (f >> 1) & 1; cy = f & 1;
    r = a;
    case (op)
      0, 1: begin
        cin = (op == 1) ? cy : 0;
        t = a + b + cin; ac = ((a & 15) + (b & 15) + cin) > 15; cy = t > 255; r = t & 255;
      end
      2, 3: begin
        cin = (op == 3) ? cy : 0;
        t = a - b - cin; ac = ((a & 15) - (b & 15) - cin) < 0; cy = t < 0; r = t & 255;
      end
      4: begin r = (b + 1) & 255; ac = (b & 15) == 15; end
      5: begin r = (b - 1) & 255; ac = (b & 15) == 0; end
      6: begin r = a & b; ac = 1; cy = 0; end
      7: begin r = a ^ b; ac = 0; cy = 0; end
      8: begin r = a | b; ac = 0; cy = 0; end
      9: begin cy = (a >> 7) & 1; r = ((a << 1) | cy) & 255; end
      10: begin cy = a & 1; r = (a >> 1) | (cy << 7); end
      11: begin
        lo = ((a & 15) > 9) || ac;
        t = a + (lo ? 6 : 0);
        ac = ((a & 15) + (lo ? 6 : 0)) > 15;
        hi = (((t & 255) >> 4) > 9) || cy;
        r = (t & 255) + (hi ? 96 : 0);
        cy = (cy || t > 255 || r > 255) ? 1 : 0;
        r = r & 255;
      end
      default: r = a;
    endcase
    if (op <= 8 || op == 11) begin
      s = (r >> 7) & 1; z = (r == 0); p = even_par(r);
    end
    return (op << 16) | (r << 8) | (s << 4) | (z << 3) | (ac << 2) | (p << 1) | cy;
  endfunction

  task automatic check_pending();
    int e, eop, er, ef;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    eop = e >> 16; er = (e >> 8) & 255; ef = e & 31;
    checks++;
    if (result_o !== 8'(er) || flags_o !== 5'(ef)) begin
      errors++;
      $display("FAIL %s op=%0d got r=%h f=%b exp r=%h f=%b",
               req_of(eop), eop, result_o, flags_o, er, ef[4:0]);
    end
  endtask

  task automatic step(int op, int a, int b, int f);
    @(negedge clk_i);
    check_pending();
    op_i = 4'(op); acc_i = 8'(a); opnd_i = 8'(b); flags_i = 5'(f);
    exp_q.push_back(model(op, a, b, f));
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op_i = 4'd0; acc_i = 8'h55; opnd_i = 8'h33; flags_i = 5'h1f;
    repeat (3) @(negedge clk_i);
    checks++; // R1 reset state
    if (result_o !== 8'h00 || flags_o !== 5'h00) begin
      errors++;
      $display("FAIL R1 reset got r=%h f=%b exp r=00 f=00000", result_o, flags_o);
    end
    rst_ni = 1'b1;
    // R2 add: nibble carry, byte carry, carry-in ignored on op 0
    step(0, 8'h3A, 8'h0C, 5'h01);
    step(0, 8'hFF, 8'h01, 5'h00);
    step(1, 8'h7F, 8'h00, 5'h01);
    step(1, 8'hF0, 8'h0F, 5'h01);
    // R3 subtract with borrow edge cases
    step(2, 8'h10, 8'h01, 5'h00);
    step(2, 8'h00, 8'h01, 5'h00);
    step(3, 8'h05, 8'h05, 5'h01);
    step(3, 8'h80, 8'h7F, 5'h00);
    // R4 inc/dec with carry kept both ways
    step(4, 8'h00, 8'hFF, 5'h01);
    step(4, 8'h00, 8'h0F, 5'h00);
    step(5, 8'hAA, 8'h00, 5'h01);
    step(5, 8'hAA, 8'h10, 5'h00);
    // R5/R6 logic flag forcing
    step(6, 8'hF0, 8'h0F, 5'h01);
    step(7, 8'hA5, 8'hA5, 5'h05);
    step(8, 8'h81, 8'h02, 5'h05);
    // R7/R8 rotates keep S Z AC P
    step(9, 8'h80, 8'h00, 5'h1E);
    step(9, 8'h01, 8'h00, 5'h01);
    step(10, 8'h01, 8'h00, 5'h0A);
    step(10, 8'h02, 8'h00, 5'h15);
    // R9/R10 decimal adjust: both corrections, AC-driven, CY-driven, overflow
    step(11, 8'h9A, 8'h00, 5'h00);
    step(11, 8'h99, 8'h00, 5'h04);
    step(11, 8'h15, 8'h00, 5'h01);
    step(11, 8'hFF, 8'h00, 5'h00);
    step(11, 8'h94, 8'h00, 5'h00);
    step(11, 8'h2B, 8'h00, 5'h00);
    // R12 reserved ops pass through
    step(12, 8'h3C, 8'hFF, 5'h15);
    step(15, 8'h00, 8'h11, 5'h0A);
    // R11 and mixed coverage
    for (int i = 0; i < 800; i++)
      step($urandom_range(15, 0), $urandom_range(255, 0), $urandom_range(255, 0),
           $urandom_range(31, 0));
    @(negedge clk_i);
    check_pending();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule